// File: doc/BRIEF.md
# Coalescing Store Buffer

This block is a small in-order queue of pending stores placed between the store execution stage and a cache write port whose data array is protected by a per-word error code. Each clock it can take at most one store, carrying a byte address, data held in the low bytes, and a size of one, two or four bytes. The store is converted into a 32-bit word address, lane-aligned data and a 4-bit byte-enable mask. The downstream port accepts exactly that form.

When a store targets the same aligned word as the most recently queued entry, it is folded into that entry instead of taking a new slot. Several narrow stores that together cover a word therefore leave the buffer as one full-word write. The cache can then compute the new check bits without first reading the old word. Entries leave strictly oldest first, whenever the downstream side is ready.

Misaligned requests are flagged with a one-cycle error and discarded. The buffer holds eight entries. It refuses new stores while all of them are occupied.

Top module: `stbuf_coalesce`

## Requirements
- R1: After synchronous reset the buffer is empty: `out_valid` is 0, `in_ready` is 1 and `in_err` is 0.
- R2: Size code 0 is a byte, 1 a halfword and 2 a word. Data is taken from the low bytes of `in_data` and placed on lanes starting at `in_addr[1:0]`, where lane k is `out_data[8k+7:8k]` and `out_be[k]`. Lanes that are not enabled read as zero.
- R3: A request is rejected when it uses size code 3, is a halfword with `in_addr[0]`=1, or is a word with `in_addr[1:0]`≠0. In that case `in_err` is 1 in the same cycle as the accepted handshake, and the queue contents do not change.
- R4: An accepted store whose word address (`in_addr[ADDR_W-1:2]`) equals that of the youngest queued entry is merged into that entry and allocates no new slot.
- R5: When merging, enabled lanes of the newer store replace the same lanes of the entry. The enable mask becomes the OR of both masks.
- R6: Only the youngest entry can absorb a store. A match with any older entry allocates a new entry.
- R7: Four byte stores that fill one word while it is the youngest entry commit as a single write with `out_be` = 4'hF.
- R8: Entries are presented on the output oldest first. `out_valid` is 1 whenever the queue is non-empty, and the head stays in place until `out_ready` is 1.
- R9: With 8 entries occupied, `in_ready` is 0. This holds even in a cycle where the head is being removed.
- R10: An entry that is handed downstream in the current cycle accepts no merge. A store to its word in that cycle allocates a new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Store request present |
| in_ready | output | 1 | Buffer can take a request this cycle |
| in_addr | input | ADDR_W | Byte address of the store |
| in_data | input | 32 | Store data, low-justified |
| in_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 invalid |
| in_err | output | 1 | Accepted request was misaligned and dropped |
| out_valid | output | 1 | Head entry available |
| out_ready | input | 1 | Cache port takes the head this cycle |
| out_waddr | output | ADDR_W-2 | Word address of the head entry |
| out_data | output | 32 | Lane-aligned data of the head entry |
| out_be | output | 4 | Byte enables of the head entry |

## Verification
The bench aims at merge eligibility, because a wrong rule either splits a word into several partial writes or merges across an older entry and reorders memory. It tests the following cases:
- a store that matches only a non-youngest entry;
- a store arriving in the same cycle as its single target entry is handed off, where a faulty design would silently lose the new bytes;
- overlapping lanes, where keeping the older byte would commit stale data;
- the full-buffer cycle with a simultaneous drain, where a combinational ready path would let a ninth store in;
- each class of misalignment, which a lax design would queue with a garbage enable mask.

// File: rtl/stbuf_pkg.sv
package stbuf_pkg;

    localparam int LANES   = 4;
    localparam int LANE_W  = 8;
    localparam int WORD_W  = LANES * LANE_W;
    localparam int OFS_W   = $clog2(LANES);

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [LANES-1:0]  lane_mask_t;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } st_size_e;

    // Lanes covered by a store of the given size at offset zero.
    function automatic lane_mask_t size_base(st_size_e sz);
        case (sz)
            SZ_BYTE: size_base = lane_mask_t'(4'b0001);
            SZ_HALF: size_base = lane_mask_t'(4'b0011);
            SZ_WORD: size_base = lane_mask_t'(4'b1111);
            default: size_base = '0;
        endcase
    endfunction

    // True when the request cannot be placed inside one aligned word.
    function automatic logic is_misaligned(st_size_e sz, logic [OFS_W-1:0] ofs);
        case (sz)
            SZ_BYTE: is_misaligned = 1'b0;
            SZ_HALF: is_misaligned = ofs[0];
            SZ_WORD: is_misaligned = (ofs != '0);
            default: is_misaligned = 1'b1;
        endcase
    endfunction

    // Lane-wise select: enabled lanes come from the new word.
    function automatic word_t lane_merge(word_t old_d, word_t new_d, lane_mask_t new_be);
        word_t res;
        for (int l = 0; l < LANES; l++) begin
            res[l*LANE_W +: LANE_W] = new_be[l] ? new_d[l*LANE_W +: LANE_W]
                                                : old_d[l*LANE_W +: LANE_W];
        end
        return res;
    endfunction

endpackage

// File: rtl/stbuf_lane_align.sv
module stbuf_lane_align
    import stbuf_pkg::*;
(
    input  logic [OFS_W-1:0] ofs,
    input  st_size_e         size,
    input  word_t            data,
    output lane_mask_t       be,
    output word_t            data_sh,
    output logic             bad
);
    logic [WORD_W+LANE_W*(LANES-1)-1:0] wide_sh;
    lane_mask_t                         base;

    always_comb begin
        bad     = is_misaligned(size, ofs);
        base    = size_base(size);
        be      = bad ? '0 : lane_mask_t'(base << ofs);
        wide_sh = {{(LANE_W*(LANES-1)){1'b0}}, data} << (LANE_W * int'(ofs));
        data_sh = lane_merge('0, word_t'(wide_sh), be);
    end

endmodule

// File: rtl/stbuf_entries.sv
module stbuf_entries
    import stbuf_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int WA_W  = 14,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc,
    input  logic             merge,
    input  logic             pop,
    input  logic [WA_W-1:0]  wr_waddr,
    input  word_t            wr_data,
    input  lane_mask_t       wr_be,
    output logic [WA_W-1:0]  head_waddr,
    output word_t            head_data,
    output lane_mask_t       head_be,
    output logic [WA_W-1:0]  young_waddr,
    output logic [CNT_W-1:0] count,
    output logic             empty,
    output logic             full
);
    localparam logic [PTR_W-1:0] LAST_IDX  = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] DEPTH_CNT = CNT_W'(DEPTH);

    logic [WA_W-1:0] waddr_q [DEPTH];
    word_t           data_q  [DEPTH];
    lane_mask_t      be_q    [DEPTH];

    logic [PTR_W-1:0] head_q, tail_q, young_idx;
    logic [CNT_W-1:0] count_q;

    function automatic logic [PTR_W-1:0] ptr_inc(logic [PTR_W-1:0] p);
        return (p == LAST_IDX) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        young_idx = (tail_q == '0) ? LAST_IDX : tail_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else begin
            if (pop)   head_q <= ptr_inc(head_q);
            if (alloc) tail_q <= ptr_inc(tail_q);
            case ({alloc, pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic do_load, do_merge;
        assign do_load  = alloc && (tail_q == PTR_W'(i));
        assign do_merge = merge && (young_idx == PTR_W'(i));

        always_ff @(posedge clk) begin
            if (do_load) begin
                waddr_q[i] <= wr_waddr;
                data_q[i]  <= wr_data;
                be_q[i]    <= wr_be;
            end else if (do_merge) begin
                data_q[i]  <= lane_merge(data_q[i], wr_data, wr_be);
                be_q[i]    <= be_q[i] | wr_be;
            end
        end
    end

    always_comb begin
        head_waddr  = waddr_q[head_q];
        head_data   = data_q[head_q];
        head_be     = be_q[head_q];
        young_waddr = waddr_q[young_idx];
        count       = count_q;
        empty       = (count_q == '0);
        full        = (count_q == DEPTH_CNT);
    end

endmodule

// File: rtl/stbuf_coalesce.sv
module stbuf_coalesce
    import stbuf_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DEPTH  = 8,
    localparam int WA_W  = ADDR_W - OFS_W,
    localparam int CNT_W = $clog2(DEPTH + 1)
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [31:0]       in_data,
    input  logic [1:0]        in_size,
    output logic              in_err,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WA_W-1:0]   out_waddr,
    output logic [31:0]       out_data,
    output logic [3:0]        out_be
);
    lane_mask_t       st_be;
    word_t            st_data;
    logic             st_bad;
    logic [WA_W-1:0]  st_waddr;

    logic [WA_W-1:0]  head_waddr, young_waddr;
    word_t            head_data;
    lane_mask_t       head_be;
    logic [CNT_W-1:0] count;
    logic             empty, full;

    logic take, pop, young_open, hit, do_merge, do_alloc;

    stbuf_lane_align u_align (
        .ofs     (in_addr[OFS_W-1:0]),
        .size    (st_size_e'(in_size)),
        .data    (word_t'(in_data)),
        .be      (st_be),
        .data_sh (st_data),
        .bad     (st_bad)
    );

    assign st_waddr = in_addr[ADDR_W-1:OFS_W];

    always_comb begin
        in_ready   = !full;
        take       = in_valid && in_ready;
        out_valid  = !empty;
        pop        = out_valid && out_ready;
        // The youngest entry stays open unless it leaves this very cycle.
        young_open = !empty && !(pop && (count == CNT_W'(1)));
        hit        = young_open && (young_waddr == st_waddr);
        do_merge   = take && !st_bad && hit;
        do_alloc   = take && !st_bad && !hit;
        in_err     = take && st_bad;
    end

    stbuf_entries #(
        .DEPTH (DEPTH),
        .WA_W  (WA_W)
    ) u_entries (
        .clk         (clk),
        .rst         (rst),
        .alloc       (do_alloc),
        .merge       (do_merge),
        .pop         (pop),
        .wr_waddr    (st_waddr),
        .wr_data     (st_data),
        .wr_be       (st_be),
        .head_waddr  (head_waddr),
        .head_data   (head_data),
        .head_be     (head_be),
        .young_waddr (young_waddr),
        .count       (count),
        .empty       (empty),
        .full        (full)
    );

    assign out_waddr = head_waddr;
    assign out_data  = head_data;
    assign out_be    = head_be;

endmodule

// File: rtl/stbuf_coalesce_chk.sv
module stbuf_coalesce_chk #(
    parameter int WA_W = 14
)(
    input logic            clk,
    input logic            rst,
    input logic            in_valid,
    input logic            in_ready,
    input logic            in_err,
    input logic            out_valid,
    input logic            out_ready,
    input logic [WA_W-1:0] out_waddr,
    input logic [3:0]      out_be
);
    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && in_ready && !in_err));

    p_dropped_no_entry_r3: assert property (@(posedge clk) disable iff (rst)
        (in_err && !out_valid) |=> !out_valid);

    p_good_store_queues_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && !in_err) |=> out_valid);

    p_head_has_lanes_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_be != 4'b0000));

    p_head_holds_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && out_waddr == $past(out_waddr)));

    p_ready_falls_on_accept_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(in_ready) |-> $past(in_valid && !in_err));

endmodule

bind stbuf_coalesce stbuf_coalesce_chk #(.WA_W(WA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_err    (in_err),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_waddr (out_waddr),
    .out_be    (out_be)
);

// File: tb/stbuf_coalesce_tb.sv
module stbuf_coalesce_tb;
    localparam int ADDR_W = 16;
    localparam int WA_W   = ADDR_W - 2;
    localparam int DEPTH  = 8;

    logic              clk = 1'b0;
    logic              rst;
    logic              in_valid;
    logic              in_ready;
    logic [ADDR_W-1:0] in_addr;
    logic [31:0]       in_data;
    logic [1:0]        in_size;
    logic              in_err;
    logic              out_valid;
    logic              out_ready;
    logic [WA_W-1:0]   out_waddr;
    logic [31:0]       out_data;
    logic [3:0]        out_be;

    always #2.5 clk = ~clk;

    stbuf_coalesce #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
        .in_data(in_data), .in_size(in_size), .in_err(in_err),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_waddr(out_waddr), .out_data(out_data), .out_be(out_be)
    );

    typedef struct {
        bit [WA_W-1:0] wa;
        bit [31:0]     d;
        bit [3:0]      be;
    } ment_t;

    ment_t q[$];
    int    checks = 0;
    int    fails  = 0;
    int    pops   = 0;
    bit    done   = 0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit model_bad(bit [1:0] sz, bit [1:0] ofs);
        return (sz == 2'd3) || (sz == 2'd1 && ofs[0]) || (sz == 2'd2 && ofs != 2'd0);
    endfunction

    // One clock: drive at the falling edge, compare, then advance the model.
    task automatic step(input bit v, input bit [ADDR_W-1:0] a, input bit [31:0] d,
                        input bit [1:0] sz, input bit ord);
        bit        e_valid, e_ready, e_err, pop, take, bad;
        int        n;
        bit [1:0]  ofs;
        bit [3:0]  be;
        bit [31:0] sd, md;
        @(negedge clk);
        in_valid = v; in_addr = a; in_data = d; in_size = sz; out_ready = ord;
        #1;
        n       = q.size();
        ofs     = a[1:0];
        bad     = model_bad(sz, ofs);
        e_valid = (n > 0);
        e_ready = (n < DEPTH);
        take    = v && e_ready;
        e_err   = take && bad;
        check(out_valid == e_valid, "R8 out_valid", out_valid, e_valid);
        check(in_ready == e_ready, "R9 in_ready", in_ready, e_ready);
        check(in_err == e_err, "R3 in_err", in_err, e_err);
        if (e_valid && out_valid) begin
            check(out_waddr == q[0].wa, "R8 out_waddr", out_waddr, q[0].wa);
            check(out_be == q[0].be, "R2 out_be", out_be, q[0].be);
            check(out_data == q[0].d, "R5 out_data", out_data, q[0].d);
        end
        pop = e_valid && ord;
        if (pop) begin
            void'(q.pop_front());
            pops++;
        end
        if (take && !bad) begin
            md = (sz == 2'd0) ? (d & 32'hFF) : (sz == 2'd1) ? (d & 32'hFFFF) : d;
            sd = md << (8 * ofs);
            be = ((sz == 2'd0) ? 4'b0001 : (sz == 2'd1) ? 4'b0011 : 4'b1111) << ofs;
            if (n > 0 && !(pop && n == 1) && q[q.size()-1].wa == a[ADDR_W-1:2]) begin
                for (int k = 0; k < 4; k++)
                    if (be[k]) q[q.size()-1].d[8*k +: 8] = sd[8*k +: 8];
                q[q.size()-1].be = q[q.size()-1].be | be;
            end else begin
                q.push_back('{wa: a[ADDR_W-1:2], d: sd, be: be});
            end
        end
    endtask

    task automatic idle(input bit ord);
        step(1'b0, '0, '0, 2'd0, ord);
    endtask

    task automatic drain();
        for (int i = 0; i < 20; i++) idle(1'b1);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; in_valid = 0; in_addr = '0; in_data = '0; in_size = '0; out_ready = 0;
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        // R1 reset state
        check(!out_valid, "R1 out_valid after reset", out_valid, 0);
        check(in_ready, "R1 in_ready after reset", in_ready, 1);
        check(!in_err, "R1 in_err after reset", in_err, 0);

        // R2 lane placement: halfword at offset 2
        step(1, 16'h0102, 32'hDEAD_BEEF, 2'd1, 0);
        idle(0);
        check(out_be == 4'b1100, "R2 halfword lanes", out_be, 4'b1100);
        check(out_data == 32'hBEEF_0000, "R2 halfword data", out_data, 32'hBEEF_0000);
        drain();

        // R5 newer bytes overwrite older ones
        step(1, 16'h0200, 32'h0000_1111, 2'd1, 0);
        step(1, 16'h0201, 32'h0000_00AB, 2'd0, 0);
        idle(0);
        check(out_data == 32'h0000_AB11, "R5 overwrite data", out_data, 32'h0000_AB11);
        check(out_be == 4'b0011, "R5 merged mask", out_be, 4'b0011);
        drain();

        // R7 / R4 four bytes fill one word -> one full write
        pops = 0;
        for (int b = 0; b < 4; b++) step(1, 16'h0040 + 16'(b), 32'h10 + 32'(b), 2'd0, 0);
        idle(0);
        check(out_be == 4'hF, "R7 full word mask", out_be, 4'hF);
        check(out_data == 32'h1312_1110, "R7 full word data", out_data, 32'h1312_1110);
        drain();
        check(pops == 1, "R4 single commit for merged word", pops, 1);

        // R6 match with older entry only -> new entry
        pops = 0;
        step(1, 16'h0300, 32'h1, 2'd0, 0);
        step(1, 16'h0304, 32'h2, 2'd0, 0);
        step(1, 16'h0301, 32'h3, 2'd0, 0);
        drain();
        check(pops == 3, "R6 older match allocates", pops, 3);

        // R10 target entry leaving this cycle is closed
        pops = 0;
        step(1, 16'h0500, 32'hA, 2'd0, 1);
        step(1, 16'h0501, 32'hB, 2'd0, 1);
        drain();
        check(pops == 2, "R10 no merge into departing entry", pops, 2);

        // R3 misaligned requests
        step(1, 16'h0601, 32'h5, 2'd1, 0);
        check(in_err, "R3 odd halfword err", in_err, 1);
        step(1, 16'h0602, 32'h5, 2'd2, 0);
        check(in_err, "R3 unaligned word err", in_err, 1);
        step(1, 16'h0600, 32'h5, 2'd3, 0);
        check(in_err, "R3 size code 3 err", in_err, 1);
        idle(0);
        check(!out_valid, "R3 dropped stores leave queue empty", out_valid, 0);

        // R9 full buffer, ready stays low during a drain cycle
        for (int i = 0; i < DEPTH; i++) step(1, 16'h0800 + 16'(4 * i), 32'(i), 2'd2, 0);
        idle(0);
        check(!in_ready, "R9 full holds ready low", in_ready, 0);
        step(1, 16'h0900, 32'h77, 2'd2, 1);
        check(!in_ready, "R9 ready low during pop", in_ready, 0);
        drain();

        // Random phase on a small set of words
        for (int c = 0; c < 4000; c++) begin
            step(($urandom % 4) != 0, 16'h0A00 + 16'($urandom % 12), $urandom,
                 2'($urandom % 4), ($urandom % 3) == 0);
        end
        drain();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule